// File: doc/BRIEF.md
# Buffered Interval Timer with Toggle Outputs

This block is a 16-bit up-counter that produces a repeating interval. It has two compare channels. Channel 0 sets the length of the interval. When the counter reaches the channel-0 value, the counter returns to zero, a one-cycle interrupt pulse is raised, and toggle output 0 inverts. The result is a 50% square wave whose half-period equals the interval. Channel 1 watches the same counter. On a match it raises its own pulse and inverts toggle output 1, without changing the interval.

The counter only advances on system clock cycles where the count-clock strobe is high. Software writes each compare value through a small write port. Each written value sits in a holding register. It moves into the compare buffer at the next counter clear, or at once while the timer is stopped. Because of this, reprogramming a running timer never shortens the interval in progress. Counting runs only while the enable input is high and the mode field selects interval operation.

Top module: `intv_timer`

## Requirements
- R1: After reset, both interrupt outputs and both toggle outputs are 0.
- R2: The timer runs only while run_en is 1 and mode is 3'b000. In every other case the counter is held at zero, both toggle outputs go to 0, and no interrupt is raised.
- R3: While running, a strobe on which the counter equals the channel-0 buffer value D0 clears the counter to 0 and raises irq0. Consecutive irq0 pulses are therefore D0+1 strobes apart, and the first one comes D0+1 strobes after the timer starts.
- R4: tog0 inverts on every channel-0 match. Its first inversion is at the first match after the timer starts.
- R5: A strobe on which the counter equals the channel-1 buffer value raises irq1 and inverts tog1.
- R6: The channel-1 value has no effect on the interval set by channel 0.
- R7: A value written while the timer runs is copied into its buffer at the next counter clear that happens in a later cycle than the write. The interval in progress keeps its old length.
- R8: While the timer is stopped, a written value reaches its buffer at once. It is used from the first count after starting.
- R9: The counter advances only on cycles where cnt_tick is 1. Each interrupt is a pulse one system clock wide for each qualifying strobe.
- R10: A channel-0 value of 0 gives an irq0 pulse and a tog0 inversion on every strobe.
- R11: The counter spans 0 to 65535. A channel-0 value of 16'hFFFF gives an interval of 65536 strobes.
- R12: Write port: wr_sel = 0 selects channel 0 and wr_sel = 1 selects channel 1. The value on wr_data is taken in the cycle where wr_en is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_tick | input | 1 | Count-clock enable strobe |
| run_en | input | 1 | Count enable |
| mode | input | 3 | Mode field; 3'b000 selects interval operation |
| wr_en | input | 1 | Compare-value write strobe |
| wr_sel | input | 1 | Channel select for the write |
| wr_data | input | 16 | Compare value to write |
| irq0 | output | 1 | Channel-0 match pulse |
| irq1 | output | 1 | Channel-1 match pulse |
| tog0 | output | 1 | Channel-0 toggle output |
| tog1 | output | 1 | Channel-1 toggle output |

## Verification
Assertions check on every cycle that a stopped timer keeps its counter at zero and its outputs quiet. They also check that a clear leaves the counter at zero, that the counter holds between strobes, that each interrupt comes with an inversion of its toggle, and that a running buffer changes only at a clear. Some behaviours can only be shown by the bench scenarios, which compare against a reference model on every clock: interval lengths such as D0+1, the deferred take-up of a value written mid-interval, the immediate take-up while stopped, the zero-value case and the full 65536-strobe interval.

// File: rtl/intv_pkg.sv
package intv_pkg;
  localparam int MODE_W = 3;
  localparam logic [MODE_W-1:0] MODE_INTERVAL = 3'b000;
  localparam int NUM_CHAN = 2;
  localparam int SEL_W = 1;
endpackage

// File: rtl/intv_counter.sv
module intv_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         tick,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (!active)      cnt_d = '0;
    else if (tick) begin
      if (clr)        cnt_d = '0;
      else            cnt_d = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  // R2: a stopped timer holds zero
  a_r2_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (cnt == '0));
  // R3: a clearing strobe leaves the counter at zero
  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (active && tick && clr) |=> (cnt == '0));
  // R9: no movement between strobes
  a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick) |=> $stable(cnt));
endmodule

// File: rtl/intv_chan.sv
module intv_chan #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         tick,
  input  logic         clr,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] cnt,
  output logic         match,
  output logic         irq,
  output logic         tog
);
  logic [W-1:0] hold_q, hold_d;
  logic [W-1:0] buf_q, buf_d;
  logic         tog_d, irq_d;

  assign match = (cnt == buf_q);

  always_comb begin
    hold_d = wr ? wdata : hold_q;
    buf_d  = buf_q;
    if (!active)  buf_d = hold_d;
    else if (clr) buf_d = hold_q;
    irq_d = active && tick && match;
    tog_d = active ? (tog ^ irq_d) : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      buf_q  <= '0;
      tog    <= 1'b0;
      irq    <= 1'b0;
    end else begin
      hold_q <= hold_d;
      buf_q  <= buf_d;
      tog    <= tog_d;
      irq    <= irq_d;
    end
  end

  // R4 / R5: every pulse comes with an inversion
  a_r4_tog_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (tog != $past(tog)));
  // R2: stopped channel is quiet and cleared
  a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!tog && !irq));
  // R7: running buffer only changes at a clear
  a_r7_buf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !clr) |=> $stable(buf_q));
endmodule

// File: rtl/intv_timer.sv
module intv_timer
  import intv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_tick,
  input  logic              run_en,
  input  logic [MODE_W-1:0] mode,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [W-1:0]      wr_data,
  output logic              irq0,
  output logic              irq1,
  output logic              tog0,
  output logic              tog1
);
  logic                active;
  logic                clr;
  logic [W-1:0]        cnt;
  logic [NUM_CHAN-1:0] match, irq, tog;

  assign active = run_en && (mode == MODE_INTERVAL);
  assign clr    = active && cnt_tick && match[0];

  intv_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .active(active), .tick(cnt_tick),
    .clr(clr), .cnt(cnt)
  );

  for (genvar i = 0; i < NUM_CHAN; i++) begin : g_chan
    intv_chan #(.W(W)) u_chan (
      .clk(clk), .rst_n(rst_n), .active(active), .tick(cnt_tick),
      .clr(clr), .wr(wr_en && (wr_sel == SEL_W'(i))), .wdata(wr_data),
      .cnt(cnt), .match(match[i]), .irq(irq[i]), .tog(tog[i])
    );
  end

  assign irq0 = irq[0];
  assign irq1 = irq[1];
  assign tog0 = tog[0];
  assign tog1 = tog[1];
endmodule

// File: tb/test_intv_timer.sv
module test_intv_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_tick = 1'b0, run_en = 1'b0, wr_en = 1'b0;
  logic [2:0]  mode = 3'b000;
  logic [0:0]  wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic        irq0, irq1, tog0, tog1;

  int checks = 0, errors = 0, cycles = 0;
  bit model_on = 0, done = 0;
  int m_cnt, m_hold[2], m_buf[2];
  bit m_irq[2], m_tog[2];

  always #10 clk = ~clk;

  intv_timer i_intv_timer (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .run_en(run_en),
    .mode(mode), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .irq0(irq0), .irq1(irq1), .tog0(tog0), .tog1(tog1)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // behavioural reference model (R2..R12)
  always @(posedge clk) begin
    cycles++;
    if (model_on) begin
      bit act, f0, f1;
      int nh[2];
      act = run_en && (mode == 3'b000);
      nh[0] = m_hold[0]; nh[1] = m_hold[1];
      if (wr_en) nh[wr_sel] = wr_data;          // R12
      if (!act) begin
        m_cnt = 0; m_tog[0] = 0; m_tog[1] = 0; m_irq[0] = 0; m_irq[1] = 0;
        m_buf[0] = nh[0]; m_buf[1] = nh[1];     // R8
      end else begin
        f0 = cnt_tick && (m_cnt == m_buf[0]);
        f1 = cnt_tick && (m_cnt == m_buf[1]);
        m_irq[0] = f0; m_irq[1] = f1;
        if (f0) m_tog[0] = !m_tog[0];
        if (f1) m_tog[1] = !m_tog[1];
        if (f0) begin
          m_cnt = 0; m_buf[0] = m_hold[0]; m_buf[1] = m_hold[1];  // R7
        end else if (cnt_tick) m_cnt = (m_cnt + 1) % 65536;
      end
      m_hold = nh;
    end
  end

  always @(negedge clk) begin
    if (model_on && !done) begin
      check(irq0 == m_irq[0], "R3 irq0", irq0, m_irq[0]);
      check(tog0 == m_tog[0], "R4 tog0", tog0, m_tog[0]);
      check(irq1 == m_irq[1], "R5 irq1", irq1, m_irq[1]);
      check(tog1 == m_tog[1], "R6 tog1", tog1, m_tog[1]);
    end
    if (cycles > 190000 && !done) begin
      done = 1;
      check(0, "watchdog", cycles, 190000);
      report();
    end
  end

  task automatic wr(input bit sel, input int val);
    wr_en = 1; wr_sel = sel; wr_data = 16'(val);
    @(negedge clk); wr_en = 0;
  endtask

  // cycles until next irq0, counted on falling edges
  task automatic gap(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!irq0 && n < 70000);
  endtask

  initial begin
    int n;
    m_cnt = 0; m_hold = '{0, 0}; m_buf = '{0, 0};
    m_irq = '{0, 0}; m_tog = '{0, 0};
    repeat (3) @(negedge clk);
    check({irq0, irq1, tog0, tog1} == 4'b0, "R1 reset", {irq0, irq1, tog0, tog1}, 0);
    rst_n = 1; model_on = 1;
    @(negedge clk);
    // R8: stopped writes land at once
    wr(0, 4); wr(1, 2);
    cnt_tick = 1; run_en = 1;
    gap(n); check(n == 5, "R8 first interval", n, 5);
    check(tog0 == 1, "R4 first inversion", tog0, 1);
    gap(n); check(n == 5, "R3 interval D0+1", n, 5);
    check(tog0 == 0, "R4 second inversion", tog0, 0);
    wr(1, 3);
    gap(n); check(n == 4, "R6 ch1 leaves interval", n, 4);
    // R7: write just after a clear; this interval keeps old length
    wr(0, 9);
    gap(n); check(n == 4, "R7 old interval kept", n, 4);
    gap(n); check(n == 10, "R7 new interval", n, 10);
    // R9: strobe every other cycle
    cnt_tick = 0; @(negedge clk);
    fork
      begin repeat (60) begin @(negedge clk); cnt_tick = ~cnt_tick; end end
      begin gap(n); gap(n); check(n == 20, "R9 half-rate interval", n, 20); end
    join
    repeat (300) begin @(negedge clk); cnt_tick = 1'($urandom_range(1)); end
    cnt_tick = 1;
    // R2: wrong mode stops everything
    mode = 3'b010;
    repeat (30) begin
      @(negedge clk);
      check({irq0, irq1, tog0, tog1} == 4'b0, "R2 mode stop", {irq0, irq1, tog0, tog1}, 0);
    end
    mode = 3'b000; run_en = 0;
    @(negedge clk);
    check(tog1 == 0, "R2 disable clears", tog1, 0);
    // R10: zero compare
    wr(0, 0); wr(1, 7);
    run_en = 1;
    repeat (8) begin
      @(negedge clk);
      check(irq0 == 1, "R10 pulse every strobe", irq0, 1);
    end
    // R11: full range
    run_en = 0; @(negedge clk);
    wr(0, 16'hFFFF);
    run_en = 1;
    gap(n); check(n == 65536, "R11 full interval", n, 65536);
    repeat (5) @(negedge clk);
    done = 1;
    report();
  end
endmodule